// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by means of a 7-bit down-counter. A prescaler divides the bus clock and steps the counter. Software must rewrite the counter (a "refresh") inside a time window. A refresh is rejected when it comes too late, because the counter has already fallen past its timeout point. It is also rejected when it comes too early, because the counter is still above a programmable window value. A rejected refresh or a timeout raises a one-cycle system reset request. One prescaler step before the timeout, an early-warning flag is set, and that flag can drive an interrupt line.

Software reaches the block through a simple strobe interface: a write strobe, a read strobe, a 2-bit address and a data word. Read data appears one clock after the read strobe. There are three registers. The control register at address 0 holds the counter in bits 6:0 and the enable in bit 7. The configuration register at address 1 holds the window value in bits 6:0, the prescaler exponent in bits 9:7 and the interrupt enable in bit 10. The status register at address 2 holds the warning flag in bit 0. Once the block is enabled, it can only be stopped by a reset.

Top module: `window_watchdog`

## Requirements
- R1: The counter decrements once every 2^(BASE_LOG2 + exponent) clock cycles, where the exponent is configuration bits 9:7. An accepted counter write restarts the prescaler, so the first step after that write comes one full period later.
- R2: The enable (control bit 7) starts at 0 after reset. Writing 1 sets it. Writing 0 leaves it unchanged.
- R3: While enabled, the step that would take the counter from 0x40 to 0x3F instead raises the reset request on that same clock edge.
- R4: A control write whose counter field (bits 6:0) has bit 6 clear raises the reset request on the write edge if the block is enabled before the write or is enabled by that write. While the block stays disabled, such a write is only loaded.
- R5: While enabled, a control write made when the current counter is greater than the window value (configuration bits 6:0) raises the reset request. When the counter is less than or equal to the window value, the write is accepted and the new value is loaded on the write edge.
- R6: The warning flag (status bit 0) is set on the step that moves the counter from 0x41 to 0x40, whether or not the interrupt is enabled. Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R7: The interrupt output equals the warning flag ANDed with the interrupt enable (configuration bit 10). The interrupt enable is set by writing 1 and is not cleared by writing 0.
- R8: The reset request lasts exactly one cycle. At that same edge every register returns to its reset value: enable 0, counter 0x7F, window 0x7F, exponent 0, interrupt enable 0, flag 0.
- R9: While disabled, the counter keeps stepping, wraps from 0x00 to 0x7F, and never raises the reset request.
- R10: Reads return the register fields at the positions given above, one cycle after the read strobe. Undefined bits and address 3 read as 0. After reset, control reads 0x007F, configuration reads 0x007F and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid the cycle after rdEn |
| irq | output | 1 | Early-warning interrupt |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
A fault in the prescaler or the counter shows up as a counter read that is off by one step at a precise cycle offset after a write. A sweep over the delays and exponents therefore catches a wrong period within one prescaler period. A wrong comparison against the window or against the 0x40 boundary shows up as a reset pulse that is missing or extra on the exact write edge, or on the exact timeout edge. A flag or enable bit that clears when it should not can be seen at the next read or on the irq pin, one cycle later.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 7;
  localparam int EXP_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int EN_BIT   = CNT_W;
  localparam int EXP_LSB  = CNT_W;
  localparam int IRQ_BIT  = CNT_W + EXP_W;
  localparam int FLAG_BIT = 0;

  localparam logic [CNT_W-1:0] WARN_VAL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] PRE_WARN_VAL = WARN_VAL + CNT_W'(1);

  typedef struct packed {
    logic             wipe;
    logic             load;
    logic [CNT_W-1:0] loadVal;
  } dpStrobe_t;
endpackage

// File: rtl/wdg_dpath.sv
module wdg_dpath
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [EXP_W-1:0] exp,
  output logic [CNT_W-1:0] cnt,
  output logic             step
);
  localparam int PRE_W = BASE_LOG2 + (1 << EXP_W);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;

  assign preLast = PRE_W'((64'd1 << (BASE_LOG2 + 32'(exp))) - 64'd1);
  assign step    = (preCnt >= preLast);

  always_ff @(posedge clk) begin
    if (rst || strobe.wipe) begin
      preCnt <= '0;
      cnt    <= '1;
    end else if (strobe.load) begin
      preCnt <= '0;
      cnt    <= strobe.loadVal;
    end else if (step) begin
      preCnt <= '0;
      cnt    <= cnt - CNT_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // R1: an unloaded step takes exactly one off the counter
  assert_step_dec_R1: assert property (@(posedge clk) disable iff (rst)
    (step && !strobe.load && !strobe.wipe) |=> (cnt == CNT_W'($past(cnt) - CNT_W'(1))));

  // R5: an accepted write appears in the counter on the next edge
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.wipe) |=> (cnt == $past(strobe.loadVal)));
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              step,
  output dpStrobe_t         strobe,
  output logic [EXP_W-1:0]  exp,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              rstReq
);
  logic             enable;
  logic             irqEn;
  logic             flag;
  logic [CNT_W-1:0] win;

  logic             wrCtl, wrCfg, wrStat;
  logic             newEn, tooEarly, tooLow, timeout, fault, warnHit;
  logic [CNT_W-1:0] newCnt;
  logic [DATA_W-1:0] rdNext;

  assign wrCtl  = wrEn && (addr == ADDR_W'(ADDR_CTRL));
  assign wrCfg  = wrEn && (addr == ADDR_W'(ADDR_CFG));
  assign wrStat = wrEn && (addr == ADDR_W'(ADDR_STAT));
  assign newCnt = wrData[CNT_W-1:0];
  assign newEn  = enable || (wrCtl && wrData[EN_BIT]);

  assign tooEarly = wrCtl && enable && (cnt > win);
  assign tooLow   = wrCtl && newEn && !newCnt[CNT_W-1];
  assign timeout  = enable && step && !wrCtl && (cnt == WARN_VAL);
  assign fault    = tooEarly || tooLow || timeout;
  assign warnHit  = step && !wrCtl && (cnt == PRE_WARN_VAL);

  assign strobe.wipe    = fault;
  assign strobe.load    = wrCtl && !fault;
  assign strobe.loadVal = newCnt;

  assign irq = flag && irqEn;

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      enable <= 1'b0;
      win    <= '1;
      exp    <= '0;
      irqEn  <= 1'b0;
      flag   <= 1'b0;
      rstReq <= fault && !rst;
    end else begin
      rstReq <= 1'b0;
      if (wrCtl && wrData[EN_BIT]) enable <= 1'b1;
      if (wrCfg) begin
        win <= wrData[CNT_W-1:0];
        exp <= wrData[EXP_LSB +: EXP_W];
        if (wrData[IRQ_BIT]) irqEn <= 1'b1;
      end
      if (warnHit)                           flag <= 1'b1;
      else if (wrStat && !wrData[FLAG_BIT])  flag <= 1'b0;
    end
  end

  always_comb begin
    rdNext = '0;
    case (addr)
      ADDR_W'(ADDR_CTRL): begin
        rdNext[CNT_W-1:0] = cnt;
        rdNext[EN_BIT]    = enable;
      end
      ADDR_W'(ADDR_CFG): begin
        rdNext[CNT_W-1:0]         = win;
        rdNext[EXP_LSB +: EXP_W]  = exp;
        rdNext[IRQ_BIT]           = irqEn;
      end
      ADDR_W'(ADDR_STAT): rdNext[FLAG_BIT] = flag;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= rdNext;
    else           rdData <= '0;
  end

  assert_enable_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    enable |=> (enable || rstReq));

  assert_timeout_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && step && (cnt == WARN_VAL) && !wrEn) |=> rstReq);

  assert_low_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (addr == ADDR_W'(ADDR_CTRL)) && enable && !wrData[CNT_W-1]) |=> rstReq);

  assert_early_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (addr == ADDR_W'(ADDR_CTRL)) && enable && (cnt > win)) |=> rstReq);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    (step && (cnt == PRE_WARN_VAL) && !wrEn) |=> flag);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rstReq |=> !rstReq);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!enable && !(wrEn && (addr == ADDR_W'(ADDR_CTRL)) && wrData[EN_BIT])) |=> !rstReq);
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 12,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              rstReq
);
  dpStrobe_t        strobe;
  logic [EXP_W-1:0] exp;
  logic [CNT_W-1:0] cnt;
  logic             step;

  wdg_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cnt(cnt), .step(step), .strobe(strobe),
    .exp(exp), .rdData(rdData), .irq(irq), .rstReq(rstReq)
  );

  wdg_dpath #(.BASE_LOG2(BASE_LOG2)) i_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .exp(exp),
    .cnt(cnt), .step(step)
  );
endmodule

// File: tb/test_window_watchdog.sv
module test_window_watchdog;
  localparam int PERIOD    = 10;
  localparam int BASE_LOG2 = 2;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic              irq;
  logic              rstReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  window_watchdog #(.BASE_LOG2(BASE_LOG2), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_window_watchdog (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .rstReq(rstReq)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic applyReset();
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    addr = ADDR_W'(a); wrData = DATA_W'(d); wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input int a, output int v);
    addr = ADDR_W'(a); rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    v = int'(rdData);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    int lim;
    applyReset();

    // R10 reset values and layout
    chk("R8 rstReq idle after reset", int'(rstReq), 0);
    chk("R7 irq idle after reset", int'(irq), 0);
    rd(0, v); chk("R10 ctrl reset", v, 'h7F);
    rd(1, v); chk("R10 cfg reset", v, 'h7F);
    rd(2, v); chk("R10 status reset", v, 0);
    rd(3, v); chk("R10 unused address", v, 0);

    // R1 sweep over exponent and delay, block disabled
    for (int e = 0; e < 3; e++) begin
      lim = (1 << BASE_LOG2) << e;
      wr(1, 'h7F | (e << 7));
      for (int d = 0; d <= 3 * lim; d++) begin
        wr(0, 'h7F);
        repeat (d) @(negedge clk);
        rd(0, v);
        chk($sformatf("R1 e=%0d d=%0d", e, d), v, 'h7F - d / lim);
      end
    end
    rd(1, v); chk("R10 cfg exponent field", v, 'h7F | (2 << 7));

    // R9 wrap and no reset while disabled, R4 low write ignored when disabled
    applyReset();
    lim = 1 << BASE_LOG2;
    wr(0, 'h3F);
    chk("R4 low write while disabled", int'(rstReq), 0);
    wr(0, 'h00);
    repeat (lim) @(negedge clk);
    rd(0, v); chk("R9 wrap to 0x7F", v, 'h7F);

    // R6/R7 flag while disabled
    wr(0, 'h41);
    repeat (lim) @(negedge clk);
    chk("R7 irq masked", int'(irq), 0);
    rd(2, v); chk("R6 flag set with irq disabled", v, 1);
    begin
      int seen = 0;
      for (int k = 0; k < 3 * lim; k++) begin
        @(negedge clk);
        if (rstReq) seen++;
      end
      chk("R9 no reset passing 0x40 while disabled", seen, 0);
    end
    wr(2, 1);
    rd(2, v); chk("R6 writing 1 keeps flag", v, 1);
    wr(1, 'h7F | (1 << 10));
    chk("R7 irq follows flag and enable", int'(irq), 1);
    wr(2, 0);
    rd(2, v); chk("R6 writing 0 clears flag", v, 0);
    chk("R7 irq drops with flag", int'(irq), 0);
    wr(1, 'h7F);
    rd(1, v); chk("R7 irq enable sticky", v, 'h7F | (1 << 10));

    // R2 enable set-only
    applyReset();
    wr(0, 'hFF);
    rd(0, v); chk("R2 enable set", v, 'hFF);
    wr(0, 'h7F);
    chk("R5 refresh at window ok", int'(rstReq), 0);
    rd(0, v); chk("R2 writing 0 keeps enable", v, 'hFF);

    // R4 low value while enabled
    wr(0, 'h3F);
    chk("R4 low write resets", int'(rstReq), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(rstReq), 0);
    rd(0, v); chk("R8 ctrl back to reset", v, 'h7F);

    // R4 low value on the enabling write
    wr(0, 'hBF);
    chk("R4 low value while enabling", int'(rstReq), 1);

    // R5 early refresh
    applyReset();
    wr(1, 'h50);
    wr(0, 'hFF);
    chk("R5 enabling write not window checked", int'(rstReq), 0);
    wr(0, 'h7F);
    chk("R5 early refresh resets", int'(rstReq), 1);
    @(negedge clk);
    rd(1, v); chk("R8 cfg back to reset", v, 'h7F);

    // R5 legal refresh at equality and below
    wr(1, 'h50);
    wr(0, 'hD0);
    wr(0, 'h50);
    chk("R5 counter equal window accepted", int'(rstReq), 0);
    wr(0, 'h45);
    chk("R5 counter below window accepted", int'(rstReq), 0);
    rd(0, v); chk("R5 new value loaded", v, 'hC5);

    // R3 timeout with early warning, exponent 1
    applyReset();
    lim = (1 << BASE_LOG2) << 1;
    wr(1, 'h7F | (1 << 7) | (1 << 10));
    wr(0, 'hC1);
    for (int k = 1; k <= 2 * lim; k++) begin
      @(negedge clk);
      if (k == lim - 1) chk("R6 no warning before step", int'(irq), 0);
      if (k == lim)     chk("R6 warning at 0x40", int'(irq), 1);
      if (k == 2 * lim - 1) chk("R3 no reset before timeout", int'(rstReq), 0);
      if (k == 2 * lim) chk("R3 reset at timeout", int'(rstReq), 1);
    end
    chk("R8 irq cleared by wipe", int'(irq), 0);
    @(negedge clk);
    chk("R8 timeout pulse one cycle", int'(rstReq), 0);
    rd(0, v); chk("R8 ctrl after timeout", v, 'h7F);
    rd(1, v); chk("R8 cfg after timeout", v, 'h7F);
    rd(2, v); chk("R8 status after timeout", v, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule